// File: doc/BRIEF.md
# SPI EEPROM Auto-Initialization Engine

After reset, this engine loads the register and RAM space of a larger block from an external serial EEPROM. When `start` is pulsed, it lowers chip select once and sends a sequential read command for byte address zero. It then clocks in words, each one made from two bytes with the high byte first. Every word is written to the matching local address and then read straight back to confirm it. Each word read within the selected span is added into a running 16-bit sum. The last word of the span carries the stored checksum and is not written.

A strap input picks the span. The short span covers the low region, which holds the registers and the default descriptor table. The long span covers the whole address space. Errors found during the pass are only recorded. They become visible on the status pins, together with a one-cycle `done`, once the pass has finished. The startup sequencer uses these flags to decide what to do next.

The local memory port is a valid/ready request channel. A request stays on the port, unchanged, until `mem_ready` is high on a clock edge. Read data returns on `mem_rvalid`/`mem_rdata` and cannot be held off: the engine keeps exactly one read outstanding and accepts the response in whatever cycle it arrives. Inside the engine, the SPI shifter pauses the serial clock, with SCK held low, whenever the verify stage has not yet taken the previous word.

Top module: `aie_autoinit`

## Requirements
- R1: Reset and idle state. After reset, the outputs are `spi_cs_n`=1, `spi_sck`=0, `busy`=0, `done`=0, `rb_err`=0, `cks_err`=0 and `mem_valid`=0. While `busy` is low, no memory request is issued.
- R2: SPI framing is mode 0, with SCK idle low and data sampled on the rising edge. A pass lowers `spi_cs_n` exactly once. It then shifts out 24 bits MSB first: opcode 0x03 followed by the 16-bit byte address 0x0000.
- R3: Each word is built from two received bytes, the first byte being bits 15:8. Word k of the stream is written to local address k.
- R4: With `span_short`=1 the span is 2^SHORT_W words (1K by default). With `span_short`=0 it is 2^ADDR_W words (32K by default). The pass reads exactly span words, which is 24 + 16·span rising SCK edges. Addresses 0 to span−2 are written. The last word of the span is the checksum and its address is left untouched.
- R5: Every write is followed by a read of the same address before the next write is issued.
- R6: If a read-back value differs from the written word, `rb_err` is set. The flag is set only in the cycle `done` is asserted and does not change while `busy` is high.
- R7: `cks_err` is set at `done` when the modulo-2^16 sum of the data words, with the checksum word left out, differs from the stored checksum word.
- R8: `done` is a single-cycle pulse, and `busy` falls in the same cycle. `rb_err` and `cks_err` keep their values until the next accepted `start`, which clears them.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R10: A `start` pulse while `busy` is high is ignored. The running pass keeps a single chip-select burst and writes each address exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a pass when idle |
| span_short | input | 1 | Range strap: 1 selects the short span, 0 the full span |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the EEPROM |
| spi_miso | input | 1 | SPI data from the EEPROM |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| rb_err | output | 1 | Read-back mismatch seen in the last pass |
| cks_err | output | 1 | Checksum mismatch in the last pass |

## Verification
The properties assume four things about the environment. The memory side returns exactly one `mem_rvalid` for each accepted read and none at any other time. `span_short` only changes between passes. `mem_ready` may drop in any cycle. The EEPROM may present any value on `spi_miso`. The bench memory model answers every accepted read one cycle later, and it drops `mem_ready` from a pseudo-random sequence to apply back-pressure. The bench changes the strap and the injected read-back corruption only between passes. Its EEPROM model changes `spi_miso` only on falling SCK edges.

// File: rtl/aie_pkg.sv
`timescale 1ns/1ps
package aie_pkg;
  localparam logic [7:0]  RD_OPCODE = 8'h03;
  localparam logic [23:0] CMD_WORD  = {RD_OPCODE, 16'h0000};
  localparam int          CMD_BITS  = 24;

  typedef enum logic [1:0] {SPI_IDLE, SPI_CMD, SPI_DATA} spi_st_t;
  typedef enum logic [1:0] {VF_IDLE, VF_WR, VF_RD, VF_WAIT} vf_st_t;
  typedef enum logic       {TOP_IDLE, TOP_RUN} top_st_t;
endpackage

// File: rtl/aie_spi_burst.sv
`timescale 1ns/1ps
// Mode-0 burst reader: sends the read command once, then streams 16-bit words.
// SCK is parked low while the previous word has not been taken.
module aie_spi_burst #(
  parameter int CNT_W    = 16,
  parameter int SCK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] nwords,
  input  logic             miso,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  output logic             wvalid,
  output logic [15:0]      wdata,
  input  logic             wready,
  output logic             fin
);
  import aie_pkg::*;

  localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  spi_st_t          st;
  logic [DIV_W-1:0] div;
  logic [4:0]       bitcnt;
  logic [22:0]      shreg;
  logic [14:0]      rx;
  logic [CNT_W-1:0] cap_cnt;
  logic             all_cap;
  logic             advance;
  logic             tick;

  assign advance = (st != SPI_IDLE) && !(all_cap && !sck) && (sck || !wvalid);
  assign tick    = advance && (div == DIV_W'(SCK_HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SPI_IDLE;
      div     <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      rx      <= '0;
      cap_cnt <= '0;
      all_cap <= 1'b0;
      wvalid  <= 1'b0;
      wdata   <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (wvalid && wready) wvalid <= 1'b0;
      if (st == SPI_IDLE) begin
        if (start) begin
          st      <= SPI_CMD;
          cs_n    <= 1'b0;
          mosi    <= CMD_WORD[23];
          shreg   <= CMD_WORD[22:0];
          bitcnt  <= '0;
          div     <= '0;
          sck     <= 1'b0;
          cap_cnt <= '0;
          all_cap <= 1'b0;
        end
      end else begin
        if (advance) div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          sck <= ~sck;
          if (!sck) begin
            // rising edge: count command bits or sample data
            if (st == SPI_CMD) begin
              bitcnt <= bitcnt + 1'b1;
            end else begin
              rx <= {rx[13:0], miso};
              if (bitcnt == 5'd15) begin
                bitcnt  <= '0;
                wvalid  <= 1'b1;
                wdata   <= {rx, miso};
                cap_cnt <= cap_cnt + 1'b1;
                if (cap_cnt == nwords - 1'b1) all_cap <= 1'b1;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end else if (st == SPI_CMD) begin
            // falling edge: present next command bit or enter data phase
            if (bitcnt == 5'(CMD_BITS)) begin
              st     <= SPI_DATA;
              bitcnt <= '0;
              mosi   <= 1'b0;
            end else begin
              mosi  <= shreg[22];
              shreg <= {shreg[21:0], 1'b0};
            end
          end
        end
        if (st == SPI_DATA && all_cap && !sck && !wvalid) begin
          st   <= SPI_IDLE;
          cs_n <= 1'b1;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aie_wr_verify.sv
`timescale 1ns/1ps
// Writes one word, reads it back, and flags a mismatch for one cycle.
module aie_wr_verify #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [15:0]       in_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  output logic              cmp_bad
);
  import aie_pkg::*;

  vf_st_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;

  assign in_ready  = (st == VF_IDLE);
  assign mem_valid = (st == VF_WR) || (st == VF_RD);
  assign mem_we    = (st == VF_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= VF_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      cmp_bad <= 1'b0;
    end else begin
      cmp_bad <= 1'b0;
      case (st)
        VF_IDLE: if (in_valid) begin
          addr_q <= in_addr;
          data_q <= in_data;
          st     <= VF_WR;
        end
        VF_WR:   if (mem_ready) st <= VF_RD;
        VF_RD:   if (mem_ready) st <= VF_WAIT;
        VF_WAIT: if (mem_rvalid) begin
          cmp_bad <= (mem_rdata != data_q);
          st      <= VF_IDLE;
        end
        default: st <= VF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aie_autoinit.sv
`timescale 1ns/1ps
module aie_autoinit #(
  parameter int ADDR_W   = 15,
  parameter int SHORT_W  = 10,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              span_short,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              rb_err,
  output logic              cks_err
);
  import aie_pkg::*;

  localparam int               CNT_W      = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_SPAN  = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [CNT_W-1:0] SHORT_SPAN = CNT_W'(1) << SHORT_W;

  top_st_t          st;
  logic [CNT_W-1:0] span_q;
  logic [CNT_W-1:0] widx;
  logic [15:0]      sum;
  logic [15:0]      stored;
  logic             pend_rb;
  logic             spi_end;

  logic             spi_go;
  logic             s_wvalid;
  logic             s_wready;
  logic [15:0]      s_wdata;
  logic             s_fin;
  logic             is_cks;
  logic             vf_in_valid;
  logic             vf_ready;
  logic             cmp_bad;

  assign spi_go      = (st == TOP_IDLE) && start;
  assign is_cks      = (widx == span_q - 1'b1);
  assign vf_in_valid = s_wvalid && !is_cks;
  assign s_wready    = is_cks || vf_ready;

  aie_spi_burst #(.CNT_W(CNT_W), .SCK_HALF(SCK_HALF)) u_spi (
    .clk(clk), .rst_n(rst_n), .start(spi_go), .nwords(span_q),
    .miso(spi_miso), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .wvalid(s_wvalid), .wdata(s_wdata), .wready(s_wready), .fin(s_fin)
  );

  aie_wr_verify #(.ADDR_W(ADDR_W)) u_vf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(vf_in_valid), .in_ready(vf_ready),
    .in_addr(widx[ADDR_W-1:0]), .in_data(s_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmp_bad(cmp_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= TOP_IDLE;
      span_q  <= SHORT_SPAN;
      widx    <= '0;
      sum     <= '0;
      stored  <= '0;
      pend_rb <= 1'b0;
      spi_end <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rb_err  <= 1'b0;
      cks_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == TOP_IDLE) begin
        if (start) begin
          st      <= TOP_RUN;
          busy    <= 1'b1;
          span_q  <= span_short ? SHORT_SPAN : FULL_SPAN;
          widx    <= '0;
          sum     <= '0;
          stored  <= '0;
          pend_rb <= 1'b0;
          spi_end <= 1'b0;
          rb_err  <= 1'b0;
          cks_err <= 1'b0;
        end
      end else begin
        if (s_wvalid && s_wready) begin
          widx <= widx + 1'b1;
          if (is_cks) stored <= s_wdata;
          else        sum    <= sum + s_wdata;
        end
        if (cmp_bad) pend_rb <= 1'b1;
        if (s_fin)   spi_end <= 1'b1;
        // errors are published only once all traffic has drained
        if (spi_end && vf_ready) begin
          st      <= TOP_IDLE;
          busy    <= 1'b0;
          done    <= 1'b1;
          rb_err  <= pend_rb | cmp_bad;
          cks_err <= (sum != stored);
        end
      end
    end
  end
endmodule

// File: rtl/aie_autoinit_chk.sv
`timescale 1ns/1ps
module aie_autoinit_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              busy,
  input logic              done,
  input logic              rb_err,
  input logic              cks_err
);
  logic [ADDR_W-1:0] last_wr;
  logic              wr_seen;
  logic              rd_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr <= '0;
      wr_seen <= 1'b0;
      rd_due  <= 1'b0;
    end else if (mem_valid && mem_ready) begin
      if (mem_we) begin
        last_wr <= mem_addr;
        wr_seen <= 1'b1;
        rd_due  <= 1'b1;
      end else begin
        rd_due  <= 1'b0;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && spi_cs_n)); // R1
  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R2
  AST_RD_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (wr_seen && mem_addr == last_wr)); // R5
  AST_NO_WR_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> !rd_due); // R5
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(rb_err) && $stable(cks_err))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && spi_cs_n)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) &&
     $stable(mem_addr) && $stable(mem_wdata))); // R9
endmodule

bind aie_autoinit aie_autoinit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
  .rb_err(rb_err), .cks_err(cks_err)
);

// File: tb/aie_autoinit_test.sv
`timescale 1ns/1ps
module aie_autoinit_test;
  localparam int ADDR_W = 6;
  localparam int SHORT_W = 4;
  localparam int FULL = 1 << ADDR_W;
  localparam int SHORT = 1 << SHORT_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, span_short = 1'b1;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso = 1'b0;
  logic mem_valid, mem_ready = 1'b0, mem_we, mem_rvalid = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 16'h0;
  logic busy, done, rb_err, cks_err;

  aie_autoinit #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .SCK_HALF(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .span_short(span_short),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .rb_err(rb_err), .cks_err(cks_err));

  int total = 0, bad = 0;
  logic [15:0] ee [0:FULL-1];
  logic [15:0] mem [0:FULL-1];

  // EEPROM model
  int bitn = 0, cs_falls = 0, rises = 0;
  logic [23:0] cmd_seen = 24'h0;
  always @(negedge spi_cs_n) begin cs_falls++; bitn = 0; end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (bitn < 24) cmd_seen = {cmd_seen[22:0], spi_mosi};
    bitn++; rises++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && bitn >= 24) begin
    int i;
    i = bitn - 24;
    if (i / 16 < FULL) spi_miso <= ee[i / 16][15 - (i % 16)];
  end

  // memory model
  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  int bad_addr = -1, wr_cnt = 0, order_bad = 0, hold_bad = 0, early = 0;
  logic rd_due = 1'b0, p_stall = 1'b0, p_we = 1'b0;
  logic [ADDR_W-1:0] p_addr = '0, last_wr = '0;
  logic [15:0] p_wdata = 16'h0;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= bp_en ? lfsr[0] : 1'b1;
    mem_rvalid <= 1'b0;
    if (rst_n) begin
      if (p_stall && !(mem_valid && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata))
        hold_bad++;
      p_stall = mem_valid && !mem_ready;
      p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          if (rd_due) order_bad++;
          mem[mem_addr] <= mem_wdata; wr_cnt++; last_wr = mem_addr; rd_due = 1'b1;
        end else begin
          if (!rd_due || mem_addr != last_wr) order_bad++;
          rd_due = 1'b0;
          mem_rvalid <= 1'b1;
          mem_rdata <= mem[mem_addr] ^ ((int'(mem_addr) == bad_addr) ? 16'h0010 : 16'h0000);
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && busy && (rb_err || cks_err)) early++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] seed, input int span, input bit good);
    logic [15:0] s;
    s = 16'h0;
    for (int k = 0; k < FULL; k++) begin
      ee[k] = (16'hF00D + 16'(k) * 16'h0B37) ^ seed;
      mem[k] = 16'hDEAD;
    end
    for (int k = 0; k < span - 1; k++) s = s + ee[k];
    ee[span - 1] = good ? s : (s ^ 16'h0101);
  endtask

  task automatic run_pass(input bit short_sel, input int restart_at);
    int n;
    cs_falls = 0; rises = 0; wr_cnt = 0; order_bad = 0; hold_bad = 0; early = 0;
    cmd_seen = 24'h0;
    @(negedge clk) begin span_short = short_sel; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      start = (n == restart_at);
    end
    start = 1'b0;
    chk("R8 pass finished", 32'(done), 32'd1);
    chk("R8 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic data_match(input string req, input int span);
    int mis;
    mis = 0;
    for (int k = 0; k < span - 1; k++) if (mem[k] !== ee[k]) mis++;
    chk(req, 32'(mis), 32'd0);
    chk("R4 checksum slot untouched", 32'(mem[span - 1]), 32'hDEAD);
  endtask

  task automatic t_reset;
    chk("R1 cs_n", 32'(spi_cs_n), 32'd1);
    chk("R1 sck", 32'(spi_sck), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 flags", {30'd0, rb_err, cks_err}, 32'd0);
    chk("R1 mem_valid", 32'(mem_valid), 32'd0);
  endtask

  task automatic t_short_clean;
    fill(16'h1234, SHORT, 1'b1);
    run_pass(1'b1, 0);
    chk("R2 command bits", 32'(cmd_seen), 32'h030000);
    chk("R2 single burst", 32'(cs_falls), 32'd1);
    chk("R4 short rising edges", 32'(rises), 32'(24 + 16 * SHORT));
    chk("R4 short write count", 32'(wr_cnt), 32'(SHORT - 1));
    data_match("R3 words at addresses", SHORT);
    chk("R5 write/read order", 32'(order_bad), 32'd0);
    chk("R7 good checksum wraps", 32'(cks_err), 32'd0);
    chk("R6 no readback error", 32'(rb_err), 32'd0);
  endtask

  task automatic t_short_badcks;
    fill(16'h8001, SHORT, 1'b0);
    run_pass(1'b1, 0);
    chk("R7 checksum mismatch", 32'(cks_err), 32'd1);
    chk("R7 readback clean", 32'(rb_err), 32'd0);
    repeat (20) @(negedge clk);
    chk("R8 flag held after done", 32'(cks_err), 32'd1);
  endtask

  task automatic t_full_bp_corrupt;
    fill(16'h0F0F, FULL, 1'b1);
    bp_en = 1'b1; bad_addr = 37;
    run_pass(1'b0, 300);
    chk("R6 readback error reported", 32'(rb_err), 32'd1);
    chk("R6 no early flag", 32'(early), 32'd0);
    chk("R7 checksum ok", 32'(cks_err), 32'd0);
    chk("R9 request held under back-pressure", 32'(hold_bad), 32'd0);
    chk("R10 single burst despite start", 32'(cs_falls), 32'd1);
    chk("R10 each address once", 32'(wr_cnt), 32'(FULL - 1));
    chk("R4 full rising edges", 32'(rises), 32'(24 + 16 * FULL));
    data_match("R3 full data", FULL);
    chk("R5 order under back-pressure", 32'(order_bad), 32'd0);
    bp_en = 1'b0; bad_addr = -1;
  endtask

  task automatic t_clear;
    chk("R8 rb_err held before start", 32'(rb_err), 32'd1);
    fill(16'h4242, SHORT, 1'b1);
    run_pass(1'b1, 0);
    chk("R8 flags cleared by new pass", {30'd0, rb_err, cks_err}, 32'd0);
    chk("R4 short again", 32'(wr_cnt), 32'(SHORT - 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_short_clean;
    t_short_badcks;
    t_full_bp_corrupt;
    t_clear;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule